// File: doc/BRIEF.md
# Opcode Fetch Substitution Interposer

This block sits between the memory data bus and the data pins of an 8-bit processor. A processor cycle is a clock cycle in which `phase2` is high. In such a cycle, `fetch_strobe` marks the byte on `mem_din` as an opcode. Data reads and writes, and fetches of ordinary opcodes, pass straight through to `cpu_dout`. A fetched byte whose three low bits are 3'b011 belongs to the reserved group, which the base processor runs as single-cycle no-operations. The block holds such a byte back and drives a substitute opcode in its place. The substitute comes from a 32-entry table indexed by the byte's upper five bits. It can be any opcode, so the processor's own address generation can do part of the work of an extended instruction.

Each fetch also captures the original memory byte into `op_latched`. The block counts the processor cycles since that fetch in `cyc_count`, and raises `ext_active` while an extended instruction runs. Together these let neighbouring logic carry out the extended instruction. The table is loaded through a small write port while reset is held.

For slow table paths, `defer_en` selects a fallback. The reserved no-operation passes through unchanged, and the table opcode is driven on the next processor cycle instead.

A three-state machine drives the behaviour:
- ST_PLAIN: an ordinary instruction is running. This is the state after reset.
- ST_EXT: an extended instruction is running.
- ST_DEFER: a substitution is owed on the next processor cycle.

The transitions below are taken only in processor cycles:
- ST_PLAIN or ST_EXT to ST_PLAIN: on an ordinary fetch.
- ST_PLAIN or ST_EXT to ST_EXT: on a reserved fetch with `defer_en` low.
- ST_PLAIN or ST_EXT to ST_DEFER: on a reserved fetch with `defer_en` high.
- ST_DEFER to ST_EXT: always, on the owed substitution cycle.
- Any other processor cycle keeps the state.

Top module: `opfetch_interposer`

## Requirements
- R1: In a processor cycle with `fetch_strobe` low, outside ST_DEFER, `cpu_dout` equals `mem_din` and `subst_active` is low. This holds even when the byte looks reserved. The same pass-through holds in any cycle with `phase2` low.
- R2: A fetch of a byte whose bits [2:0] are not 3'b011 passes through unchanged, with `subst_active` low.
- R3: With `defer_en` low, a fetch of a byte whose bits [2:0] are 3'b011 drives the table entry indexed by bits [7:3] of the byte onto `cpu_dout`, with `subst_active` high, in the same cycle.
- R4: A table write takes effect on a clock edge only while `rst_n` is low. A write issued while `rst_n` is high leaves the entry unchanged. The table is not cleared by reset.
- R5: Each fetch outside ST_DEFER loads the original `mem_din` byte into `op_latched`, never the substitute. The value holds until the next such fetch.
- R6: `cyc_count` becomes 0 after a fetch cycle. It rises by one after each other processor cycle and saturates at 7.
- R7: `ext_active` rises after a reserved fetch and stays high until the edge that ends the next ordinary fetch.
- R8: With `defer_en` high, a reserved fetch passes through unchanged, and the state moves to ST_DEFER. The next processor cycle drives the table entry indexed by `op_latched[7:3]`, whatever `fetch_strobe` and `mem_din` are. That cycle leaves `op_latched` unchanged, sets `cyc_count` to 0, and moves the state to ST_EXT.
- R9: After reset, `op_latched` is 0, `cyc_count` is 0, `ext_active` is low and data passes through.
- R10: Cycles with `phase2` low change no state. This includes `fetch_strobe` being high: nothing is captured, counted or decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset; also enables table writes |
| tbl_we | input | 1 | Table write enable, honoured only in reset |
| tbl_addr | input | 5 | Table entry to write |
| tbl_wdata | input | 8 | Substitute opcode to write |
| defer_en | input | 1 | Fallback mode: substitute one processor cycle later |
| fetch_strobe | input | 1 | High when the processor fetches an opcode |
| phase2 | input | 1 | High in the clock cycle that forms one processor cycle |
| mem_din | input | 8 | Byte from the memory bus |
| cpu_dout | output | 8 | Byte presented to the processor |
| subst_active | output | 1 | High while a substitute opcode is driven |
| op_latched | output | 8 | Original byte of the last opcode fetch |
| ext_active | output | 1 | High while an extended instruction runs |
| cyc_count | output | 3 | Processor cycles since the last fetch, saturating |

## Verification
The assertions assume that `fetch_strobe`, `defer_en` and `mem_din` are steady and meaningful only while `phase2` is high. They also assume that `defer_en` does not change between a reserved fetch and its owed substitution cycle, and that table writes arrive only while reset is held. The stimulus changes inputs one time unit after a rising edge and checks at the falling edge. It keeps `defer_en` fixed around each reserved fetch. It issues its single out-of-reset table write on purpose, to show that such a write is ignored.

// File: rtl/opsub_pkg.sv
package opsub_pkg;

    localparam int RSV_BITS = 3;
    localparam logic [RSV_BITS-1:0] RSV_PAT = 3'b011;

    typedef enum logic [1:0] {
        ST_PLAIN = 2'd0,
        ST_EXT   = 2'd1,
        ST_DEFER = 2'd2
    } track_e;

    function automatic logic is_reserved(input logic [RSV_BITS-1:0] low_bits);
        return low_bits == RSV_PAT;
    endfunction

endpackage

// File: rtl/opsub_table.sv
module opsub_table
    import opsub_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DEPTH*DATA_W-1:0] entries_q;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n && wr_en && (wr_idx == IDX_W'(gi))) begin
                entries_q[gi*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end

    assign rd_data = entries_q[rd_idx*DATA_W +: DATA_W];

    // A write attempted outside reset must not alter any entry.
    assert_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable(entries_q));

endmodule

// File: rtl/opsub_tracker.sv
module opsub_tracker
    import opsub_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3,
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase2,
    input  logic              fetch_strobe,
    input  logic              defer_en,
    input  logic [DATA_W-1:0] mem_din,
    output track_e            state,
    output logic [DATA_W-1:0] op_q,
    output logic [CNT_W-1:0]  cnt_q
);

    track_e state_q, state_d;
    logic   rsv_now;

    assign rsv_now = is_reserved(mem_din[RSV_BITS-1:0]);
    assign state   = state_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PLAIN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions, taken only in processor cycles.
    always_comb begin
        state_d = state_q;
        if (phase2) begin
            unique case (state_q)
                ST_PLAIN, ST_EXT: begin
                    if (fetch_strobe) begin
                        if (!rsv_now)      state_d = ST_PLAIN;
                        else if (defer_en) state_d = ST_DEFER;
                        else               state_d = ST_EXT;
                    end
                end
                ST_DEFER: state_d = ST_EXT;
                default:  state_d = ST_PLAIN;
            endcase
        end
    end

    // Opcode capture and cycle counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            cnt_q <= '0;
        end else if (phase2) begin
            if (state_q == ST_DEFER) begin
                cnt_q <= '0;
            end else if (fetch_strobe) begin
                op_q  <= mem_din;
                cnt_q <= '0;
            end else if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        phase2 && fetch_strobe && (state_q != ST_DEFER) |=> op_q == $past(mem_din));

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !phase2 |=> $stable(op_q) && $stable(cnt_q) && $stable(state_q));

    assert_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        phase2 && !fetch_strobe && (state_q != ST_DEFER) && (cnt_q != CNT_MAX)
        |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        phase2 && !fetch_strobe && (state_q != ST_DEFER) && (cnt_q == CNT_MAX)
        |=> cnt_q == CNT_MAX);

    assert_defer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        phase2 && (state_q == ST_DEFER)
        |=> (state_q == ST_EXT) && (op_q == $past(op_q)) && (cnt_q == '0));

endmodule

// File: rtl/opsub_route.sv
module opsub_route
    import opsub_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5
) (
    input  track_e            state,
    input  logic              phase2,
    input  logic              fetch_strobe,
    input  logic              defer_en,
    input  logic [DATA_W-1:0] mem_din,
    input  logic [DATA_W-1:0] op_q,
    input  logic [DATA_W-1:0] tbl_data,
    output logic [IDX_W-1:0]  tbl_idx,
    output logic [DATA_W-1:0] cpu_dout,
    output logic              subst,
    output logic              ext
);

    // Output process: select the byte for the processor.
    always_comb begin
        subst   = 1'b0;
        tbl_idx = mem_din[DATA_W-1 -: IDX_W];
        ext     = 1'b0;
        unique case (state)
            ST_PLAIN: begin
                subst = phase2 && fetch_strobe && !defer_en
                        && is_reserved(mem_din[RSV_BITS-1:0]);
            end
            ST_EXT: begin
                ext   = 1'b1;
                subst = phase2 && fetch_strobe && !defer_en
                        && is_reserved(mem_din[RSV_BITS-1:0]);
            end
            ST_DEFER: begin
                ext     = 1'b1;
                tbl_idx = op_q[DATA_W-1 -: IDX_W];
                subst   = phase2;
            end
            default: begin
                subst = 1'b0;
            end
        endcase
        cpu_dout = subst ? tbl_data : mem_din;
    end

endmodule

// File: rtl/opfetch_interposer.sv
module opfetch_interposer
    import opsub_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3,
    localparam int IDX_W = DATA_W - RSV_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_addr,
    input  logic [DATA_W-1:0] tbl_wdata,
    input  logic              defer_en,
    input  logic              fetch_strobe,
    input  logic              phase2,
    input  logic [DATA_W-1:0] mem_din,
    output logic [DATA_W-1:0] cpu_dout,
    output logic              subst_active,
    output logic [DATA_W-1:0] op_latched,
    output logic              ext_active,
    output logic [CNT_W-1:0]  cyc_count
);

    track_e             trk_state;
    logic [IDX_W-1:0]   rd_idx;
    logic [DATA_W-1:0]  rd_data;

    opsub_table #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_addr),
        .wr_data (tbl_wdata),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    opsub_tracker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase2       (phase2),
        .fetch_strobe (fetch_strobe),
        .defer_en     (defer_en),
        .mem_din      (mem_din),
        .state        (trk_state),
        .op_q         (op_latched),
        .cnt_q        (cyc_count)
    );

    opsub_route #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_route (
        .state        (trk_state),
        .phase2       (phase2),
        .fetch_strobe (fetch_strobe),
        .defer_en     (defer_en),
        .mem_din      (mem_din),
        .op_q         (op_latched),
        .tbl_data     (rd_data),
        .tbl_idx      (rd_idx),
        .cpu_dout     (cpu_dout),
        .subst        (subst_active),
        .ext          (ext_active)
    );

    assert_datapass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        phase2 && !fetch_strobe && (trk_state != ST_DEFER)
        |-> !subst_active && (cpu_dout == mem_din));

    assert_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        phase2 && fetch_strobe && !defer_en && (trk_state != ST_DEFER)
        && is_reserved(mem_din[RSV_BITS-1:0]) |=> ext_active);

    assert_ordinary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase2 && fetch_strobe && (trk_state != ST_DEFER)
        && !is_reserved(mem_din[RSV_BITS-1:0]) |-> !subst_active);

endmodule

// File: tb/opfetch_interposer_bench.sv
module opfetch_interposer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tbl_we = 1'b0;
    logic [4:0] tbl_addr = '0;
    logic [7:0] tbl_wdata = '0;
    logic       defer_en = 1'b0;
    logic       fetch_strobe = 1'b0;
    logic       phase2 = 1'b0;
    logic [7:0] mem_din = '0;
    logic [7:0] cpu_dout;
    logic       subst_active;
    logic [7:0] op_latched;
    logic       ext_active;
    logic [2:0] cyc_count;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    opfetch_interposer u_opfetch_interposer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tbl_we       (tbl_we),
        .tbl_addr     (tbl_addr),
        .tbl_wdata    (tbl_wdata),
        .defer_en     (defer_en),
        .fetch_strobe (fetch_strobe),
        .phase2       (phase2),
        .mem_din      (mem_din),
        .cpu_dout     (cpu_dout),
        .subst_active (subst_active),
        .op_latched   (op_latched),
        .ext_active   (ext_active),
        .cyc_count    (cyc_count)
    );

    function automatic logic [7:0] tv(input int i);
        return 8'((i * 37) + 11);
    endfunction

    // {defer, strobe, phase2, mem, exp_dout, exp_subst, exp_op, exp_ext, exp_cyc}
    function automatic logic [31:0] mk(input logic df, input logic st, input logic ph,
                                       input logic [7:0] m, input logic [7:0] d,
                                       input logic s, input logic [7:0] o,
                                       input logic e, input logic [2:0] c);
        return {df, st, ph, m, d, s, o, e, c};
    endfunction

    localparam int NV = 20;
    localparam logic [31:0] VEC [NV] = '{
        mk(0,0,1,8'h55,8'h55,0,8'h00,0,3'd0),   // R1 data cycle
        mk(0,1,1,8'hA9,8'hA9,0,8'h00,0,3'd1),   // R2 ordinary fetch
        mk(0,0,1,8'h12,8'h12,0,8'hA9,0,3'd0),
        mk(0,0,0,8'h34,8'h34,0,8'hA9,0,3'd1),   // R10 phase2 low
        mk(0,1,0,8'h03,8'h03,0,8'hA9,0,3'd1),   // R10 strobe ignored
        mk(0,1,1,8'h03,tv(0),1,8'hA9,0,3'd1),   // R3 reserved, index 0
        mk(0,0,1,8'h03,8'h03,0,8'h03,1,3'd0),   // R1 reserved-looking data
        mk(0,0,1,8'h77,8'h77,0,8'h03,1,3'd1),
        mk(0,1,1,8'hFB,tv(31),1,8'h03,1,3'd2),  // R3 index 31
        mk(0,1,1,8'h4C,8'h4C,0,8'hFB,1,3'd0),   // R7 clears after
        mk(0,1,1,8'h8B,tv(17),1,8'h4C,0,3'd0),  // R3 index 17
        mk(0,1,1,8'hEA,8'hEA,0,8'h8B,1,3'd0),
        mk(1,1,1,8'h5B,8'h5B,0,8'hEA,0,3'd0),   // R8 reserved passes
        mk(1,1,1,8'h60,tv(11),1,8'h5B,1,3'd0),  // R8 owed cycle
        mk(1,0,1,8'h21,8'h21,0,8'h5B,1,3'd0),
        mk(1,1,1,8'h0F,8'h0F,0,8'h5B,1,3'd1),
        mk(1,1,1,8'hC3,8'hC3,0,8'h0F,0,3'd0),   // R8 second reserved
        mk(1,0,0,8'h99,8'h99,0,8'hC3,1,3'd0),   // R10 owed cycle waits
        mk(1,0,1,8'h99,tv(24),1,8'hC3,1,3'd0),  // R8 owed, no strobe
        mk(0,1,1,8'hA0,8'hA0,0,8'hC3,1,3'd0)
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic df, input logic st, input logic ph, input logic [7:0] m);
        @(posedge clk);
        #1;
        defer_en = df; fetch_strobe = st; phase2 = ph; mem_din = m;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // Load the table while reset is held (R4).
        for (int i = 0; i < 32; i++) begin
            @(posedge clk);
            #1;
            tbl_we = 1'b1; tbl_addr = 5'(i); tbl_wdata = tv(i);
        end
        @(posedge clk);
        #1;
        tbl_we = 1'b0;
        phase2 = 1'b1; mem_din = 8'h5A;
        @(negedge clk);
        chk("R9 op_latched", op_latched, 8'h00);
        chk("R9 cyc_count", 8'(cyc_count), 8'h00);
        chk("R9 ext_active", 8'(ext_active), 8'h00);
        chk("R9 pass", cpu_dout, 8'h5A);
        @(posedge clk);
        #1;
        rst_n = 1'b1; phase2 = 1'b0;

        for (int v = 0; v < NV; v++) begin
            drive(VEC[v][31], VEC[v][30], VEC[v][29], VEC[v][28:21]);
            chk("R1 R2 R3 R8 cpu_dout", cpu_dout, VEC[v][20:13]);
            chk("R1 R2 R3 R8 subst_active", 8'(subst_active), 8'(VEC[v][12]));
            chk("R5 op_latched", op_latched, VEC[v][11:4]);
            chk("R7 ext_active", 8'(ext_active), 8'(VEC[v][3]));
            chk("R6 cyc_count", 8'(cyc_count), 8'(VEC[v][2:0]));
        end

        // R6 saturation after the last fetch of the table.
        for (int k = 1; k <= 10; k++) begin
            drive(1'b0, 1'b0, 1'b1, 8'(k));
            chk("R6 saturate", 8'(cyc_count), (k - 1) > 7 ? 8'd7 : 8'(k - 1));
        end

        // R10 strobe with phase2 low captures nothing.
        drive(1'b0, 1'b1, 1'b0, 8'h3B);
        chk("R10 pass", cpu_dout, 8'h3B);
        drive(1'b0, 1'b0, 1'b0, 8'h00);
        chk("R10 op_latched", op_latched, 8'hA0);
        chk("R10 cyc_count", 8'(cyc_count), 8'd7);
        chk("R10 ext_active", 8'(ext_active), 8'd0);

        // R4 a write outside reset is ignored.
        @(posedge clk);
        #1;
        tbl_we = 1'b1; tbl_addr = 5'd0; tbl_wdata = 8'hEE;
        @(posedge clk);
        #1;
        tbl_we = 1'b0;
        fetch_strobe = 1'b1; phase2 = 1'b1; mem_din = 8'h03;
        @(negedge clk);
        chk("R4 locked entry", cpu_dout, tv(0));
        chk("R3 subst_active", 8'(subst_active), 8'd1);
        @(posedge clk);
        #1;
        fetch_strobe = 1'b0; mem_din = 8'h44;
        @(negedge clk);
        chk("R5 original byte", op_latched, 8'h03);
        chk("R7 ext after reserved", 8'(ext_active), 8'd1);

        // R9 reset in mid-instruction clears tracking state.
        rst_n = 1'b0;
        #1;
        chk("R9 reset op_latched", op_latched, 8'h00);
        chk("R9 reset ext_active", 8'(ext_active), 8'd0);
        chk("R9 reset cyc_count", 8'(cyc_count), 8'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule